// File: doc/BRIEF.md
# CAN Transmit Mailbox Priority Arbiter

This block decides which message slot in a bank of 32 is handed next to the CAN bus engine. Software configures the bank through a small word-addressed register port. Four bit-per-slot registers hold the slot enables, the slot directions, the pending transmit requests and the completion flags. A separate 14-bit control word per slot carries the data length, the remote-frame flag and a 6-bit transmit priority.

Every cycle the block looks at all slots that are enabled, set to transmit and have a request pending. It selects the one with the largest priority value. Among slots with equal priority, the higher slot number wins. It then registers the winner's number, length and remote flag together with a valid flag. The valid flag is raised only while the bus engine signals that it is ready. When the engine reports that a frame has gone out, it pulses a done input with the slot number. The block then drops that slot's request and raises its completion flag in the same cycle.

Register map (word address, 6 bits): bit 5 set selects the control word of the slot given by bits 4:0. With bit 5 clear, offset 0 is the enable mask, 1 the direction mask (1 = receive, 0 = transmit), 2 the request register and 3 the completion register. Other offsets read 0 and ignore writes.

Top module: `can_txmb_arbiter`

## Requirements
- R1: After synchronous reset the enable, direction, request and completion registers and all control words read 0, and grant_valid is 0.
- R2: A slot takes part in arbitration only when its enable bit is 1, its direction bit is 0 and its request bit is 1.
- R3: Among eligible slots the one whose control-word bits 13:8 hold the largest value is granted.
- R4: When several eligible slots share the largest priority value, the highest slot number is granted.
- R5: Writing offset 2 sets the request bit of every slot whose data bit is 1; data bits of 0 leave requests unchanged; reading offset 2 returns the pending requests.
- R6: A done pulse for slot n sets completion bit n and clears request bit n at the same clock edge, so slot n is not granted again unless it is requested again.
- R7: Writing offset 3 clears each completion bit whose data bit is 1; data bits of 0 leave it unchanged.
- R8: The grant outputs are registered and reflect the register state one clock edge earlier; grant_valid is 0 when no slot is eligible or eng_ready was low.
- R9: A pending slot whose enable bit is cleared is no longer granted from the next grant update.
- R10: grant_dlc and grant_rtr carry bits 3:0 and bit 4 of the granted slot's control word.
- R11: A control-word write stores data bits 13:0; reading the control word returns them with bits 31:14 as 0.
- R12: When a request write and a done pulse hit the same slot at the same edge, the request stays set and the completion bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read word address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| eng_ready | input | 1 | Bus engine can accept a frame |
| tx_done | input | 1 | Frame of slot done_idx has been sent |
| done_idx | input | 5 | Slot number for tx_done |
| grant_valid | output | 1 | A slot is granted |
| grant_idx | output | 5 | Granted slot number |
| grant_dlc | output | 4 | Data length of the granted slot |
| grant_rtr | output | 1 | Remote-frame flag of the granted slot |

## Verification
A register write or a done pulse changes the readable register state at the clock edge that captures it. The read port then shows the new value before the following edge. The grant outputs follow one further edge later, because the comparison result is captured in a register. The bench therefore reads registers at the falling edge right after the updating edge, and waits one more rising edge before it samples the grant. One check samples the grant on the very first falling edge on purpose, to show that the lag is a single cycle.

// File: rtl/txarb_pkg.sv
package txarb_pkg;

    localparam int MB_COUNT = 32;
    localparam int MB_IDX_W = $clog2(MB_COUNT);
    localparam int PRIO_W   = 6;
    localparam int PRIO_LSB = 8;
    localparam int RTR_BIT  = 4;
    localparam int DLC_W    = 4;
    localparam int CTL_W    = PRIO_LSB + PRIO_W;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = MB_IDX_W + 1;

    typedef enum logic [1:0] {
        GREG_ENABLE = 2'd0,
        GREG_DIR    = 2'd1,
        GREG_REQ    = 2'd2,
        GREG_ACK    = 2'd3
    } greg_e;

    typedef struct packed {
        logic                is_ctl;
        logic [MB_IDX_W-1:0] off;
    } addr_t;

    typedef struct packed {
        logic                vld;
        logic [PRIO_W-1:0]   prio;
        logic [MB_IDX_W-1:0] idx;
    } cand_t;

    typedef struct packed {
        logic                vld;
        logic [MB_IDX_W-1:0] idx;
        logic [DLC_W-1:0]    dlc;
        logic                rtr;
    } grant_t;

    function automatic logic [PRIO_W-1:0] ctl_prio(input logic [CTL_W-1:0] w);
        return w[PRIO_LSB +: PRIO_W];
    endfunction

    function automatic logic [DLC_W-1:0] ctl_dlc(input logic [CTL_W-1:0] w);
        return w[DLC_W-1:0];
    endfunction

    function automatic logic ctl_rtr(input logic [CTL_W-1:0] w);
        return w[RTR_BIT];
    endfunction

    function automatic logic glob_hit(input addr_t a, input greg_e sel);
        return !a.is_ctl && (a.off == MB_IDX_W'(sel));
    endfunction

    // hi always carries the higher slot numbers, so equal priority favours it
    function automatic cand_t pick_upper(input cand_t lo, input cand_t hi);
        if (hi.vld && (!lo.vld || hi.prio >= lo.prio))
            return hi;
        return lo;
    endfunction

endpackage

// File: rtl/txarb_regs.sv
module txarb_regs
    import txarb_pkg::*;
#(
    parameter int NUM_MB = MB_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                done,
    input  logic [MB_IDX_W-1:0] done_idx,
    output logic [NUM_MB-1:0]   en_q,
    output logic [NUM_MB-1:0]   dir_q,
    output logic [NUM_MB-1:0]   req_q,
    output logic [NUM_MB-1:0]   ack_q,
    output logic [CTL_W-1:0]    ctl_q [NUM_MB]
);

    addr_t wa;
    addr_t ra;
    logic [NUM_MB-1:0] wdat;
    logic [NUM_MB-1:0] done_vec;
    logic [NUM_MB-1:0] set_vec;
    logic [NUM_MB-1:0] clr_vec;
    logic hit_en, hit_dir, hit_req, hit_ack;

    assign wa   = addr_t'(wr_addr);
    assign ra   = addr_t'(rd_addr);
    assign wdat = wr_data[NUM_MB-1:0];

    assign hit_en  = wr_en && glob_hit(wa, GREG_ENABLE);
    assign hit_dir = wr_en && glob_hit(wa, GREG_DIR);
    assign hit_req = wr_en && glob_hit(wa, GREG_REQ);
    assign hit_ack = wr_en && glob_hit(wa, GREG_ACK);

    assign done_vec = done    ? (NUM_MB'(1) << done_idx) : '0;
    assign set_vec  = hit_req ? wdat : '0;
    assign clr_vec  = hit_ack ? wdat : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            dir_q <= '0;
            req_q <= '0;
            ack_q <= '0;
        end else begin
            if (hit_en)
                en_q <= wdat;
            if (hit_dir)
                dir_q <= wdat;
            // a new request written at the done edge survives
            req_q <= (req_q & ~done_vec) | set_vec;
            ack_q <= (ack_q & ~clr_vec) | done_vec;
        end
    end

    for (genvar m = 0; m < NUM_MB; m++) begin : g_ctl
        logic [CTL_W-1:0] word;
        always_ff @(posedge clk) begin
            if (rst)
                word <= '0;
            else if (wr_en && wa.is_ctl && wa.off == MB_IDX_W'(m))
                word <= wr_data[CTL_W-1:0];
        end
        assign ctl_q[m] = word;
    end

    always_comb begin
        rd_data = '0;
        if (ra.is_ctl) begin
            if (int'(ra.off) < NUM_MB)
                rd_data = DATA_W'(ctl_q[ra.off]);
        end else begin
            unique case (ra.off)
                MB_IDX_W'(GREG_ENABLE): rd_data = DATA_W'(en_q);
                MB_IDX_W'(GREG_DIR):    rd_data = DATA_W'(dir_q);
                MB_IDX_W'(GREG_REQ):    rd_data = DATA_W'(req_q);
                MB_IDX_W'(GREG_ACK):    rd_data = DATA_W'(ack_q);
                default:                rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/txarb_pick.sv
module txarb_pick
    import txarb_pkg::*;
#(
    parameter int NUM_MB = MB_COUNT
) (
    input  logic [NUM_MB-1:0] elig,
    input  logic [PRIO_W-1:0] prio [NUM_MB],
    output cand_t             best
);

    localparam int LVLS = $clog2(NUM_MB);
    localparam int PAD  = 1 << LVLS;

    for (genvar lv = 0; lv <= LVLS; lv++) begin : g_lvl
        localparam int WID = PAD >> lv;
        cand_t nd [WID];
        if (lv == 0) begin : g_leaf
            for (genvar i = 0; i < WID; i++) begin : g_in
                if (i < NUM_MB) begin : g_real
                    assign nd[i] = '{vld: elig[i], prio: prio[i], idx: MB_IDX_W'(i)};
                end else begin : g_pad
                    assign nd[i] = '0;
                end
            end
        end else begin : g_node
            for (genvar j = 0; j < WID; j++) begin : g_cmp
                assign nd[j] = pick_upper(g_lvl[lv-1].nd[2*j], g_lvl[lv-1].nd[2*j+1]);
            end
        end
    end

    assign best = g_lvl[LVLS].nd[0];

endmodule

// File: rtl/txarb_grant.sv
module txarb_grant
    import txarb_pkg::*;
#(
    parameter int NUM_MB = MB_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ready,
    input  cand_t            best,
    input  logic [CTL_W-1:0] ctl_q [NUM_MB],
    output grant_t           grant
);

    logic [CTL_W-1:0] win_ctl;

    assign win_ctl = ctl_q[best.idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            grant <= '0;
        end else if (ready && best.vld) begin
            grant.vld <= 1'b1;
            grant.idx <= best.idx;
            grant.dlc <= ctl_dlc(win_ctl);
            grant.rtr <= ctl_rtr(win_ctl);
        end else begin
            grant <= '0;
        end
    end

endmodule

// File: rtl/can_txmb_arbiter.sv
module can_txmb_arbiter
    import txarb_pkg::*;
#(
    parameter int NUM_MB = MB_COUNT
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                eng_ready,
    input  logic                tx_done,
    input  logic [MB_IDX_W-1:0] done_idx,
    output logic                grant_valid,
    output logic [MB_IDX_W-1:0] grant_idx,
    output logic [DLC_W-1:0]    grant_dlc,
    output logic                grant_rtr
);

    logic [NUM_MB-1:0] en_q;
    logic [NUM_MB-1:0] dir_q;
    logic [NUM_MB-1:0] req_q;
    logic [NUM_MB-1:0] ack_q;
    logic [CTL_W-1:0]  ctl_q [NUM_MB];
    logic [PRIO_W-1:0] mb_prio [NUM_MB];
    logic [NUM_MB-1:0] elig;
    cand_t             best;
    grant_t            grant;

    txarb_regs #(.NUM_MB(NUM_MB)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .done     (tx_done),
        .done_idx (done_idx),
        .en_q     (en_q),
        .dir_q    (dir_q),
        .req_q    (req_q),
        .ack_q    (ack_q),
        .ctl_q    (ctl_q)
    );

    for (genvar m = 0; m < NUM_MB; m++) begin : g_prio
        assign mb_prio[m] = ctl_prio(ctl_q[m]);
    end

    assign elig = en_q & ~dir_q & req_q;

    txarb_pick #(.NUM_MB(NUM_MB)) u_pick (
        .elig (elig),
        .prio (mb_prio),
        .best (best)
    );

    txarb_grant #(.NUM_MB(NUM_MB)) u_grant (
        .clk   (clk),
        .rst   (rst),
        .ready (eng_ready),
        .best  (best),
        .ctl_q (ctl_q),
        .grant (grant)
    );

    assign grant_valid = grant.vld;
    assign grant_idx   = grant.idx;
    assign grant_dlc   = grant.dlc;
    assign grant_rtr   = grant.rtr;

endmodule

// File: rtl/txarb_chk.sv
module txarb_chk
    import txarb_pkg::*;
#(
    parameter int NUM_MB = MB_COUNT
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_addr,
    input logic [DATA_W-1:0]   wr_data,
    input logic                eng_ready,
    input logic                tx_done,
    input logic [MB_IDX_W-1:0] done_idx,
    input logic [NUM_MB-1:0]   en_q,
    input logic [NUM_MB-1:0]   dir_q,
    input logic [NUM_MB-1:0]   req_q,
    input logic [NUM_MB-1:0]   ack_q,
    input logic [PRIO_W-1:0]   mb_prio [NUM_MB],
    input logic                grant_valid,
    input logic [MB_IDX_W-1:0] grant_idx
);

    logic [NUM_MB-1:0] elig_d;
    logic [PRIO_W-1:0] prio_d [NUM_MB];
    logic              rdy_d;
    logic              beat_prio;
    logic              beat_tie;
    logic              set_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            elig_d <= '0;
            rdy_d  <= 1'b0;
            for (int k = 0; k < NUM_MB; k++) prio_d[k] <= '0;
        end else begin
            elig_d <= en_q & ~dir_q & req_q;
            rdy_d  <= eng_ready;
            for (int k = 0; k < NUM_MB; k++) prio_d[k] <= mb_prio[k];
        end
    end

    always_comb begin
        beat_prio = 1'b0;
        beat_tie  = 1'b0;
        for (int j = 0; j < NUM_MB; j++) begin
            if (elig_d[j] && prio_d[j] > prio_d[grant_idx])
                beat_prio = 1'b1;
            if (elig_d[j] && prio_d[j] == prio_d[grant_idx] && j > int'(grant_idx))
                beat_tie = 1'b1;
        end
    end

    assign set_hit = wr_en && wr_addr == ADDR_W'(GREG_REQ) && wr_data[done_idx];

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> elig_d[grant_idx]); // R2

    AST_NO_HIGHER_PRIO: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !beat_prio); // R3

    AST_TIE_HIGH_INDEX: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> !beat_tie); // R4

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (rst)
        grant_valid == (rdy_d && (|elig_d))); // R8

    AST_DONE_SETS_ACK: assert property (@(posedge clk) disable iff (rst)
        tx_done |=> ack_q[$past(done_idx)]); // R6

    AST_DONE_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !set_hit) |=> !req_q[$past(done_idx)]); // R6

endmodule

bind can_txmb_arbiter txarb_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .eng_ready   (eng_ready),
    .tx_done     (tx_done),
    .done_idx    (done_idx),
    .en_q        (en_q),
    .dir_q       (dir_q),
    .req_q       (req_q),
    .ack_q       (ack_q),
    .mb_prio     (mb_prio),
    .grant_valid (grant_valid),
    .grant_idx   (grant_idx)
);

// File: tb/sim_can_txmb_arbiter.sv
module sim_can_txmb_arbiter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        eng_ready = 1'b1;
    logic        tx_done = 1'b0;
    logic [4:0]  done_idx = '0;
    logic        grant_valid;
    logic [4:0]  grant_idx;
    logic [3:0]  grant_dlc;
    logic        grant_rtr;

    int checks = 0;
    int errors = 0;

    always #(2.5ns) clk = ~clk;

    can_txmb_arbiter u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .eng_ready(eng_ready),
        .tx_done(tx_done), .done_idx(done_idx), .grant_valid(grant_valid),
        .grant_idx(grant_idx), .grant_dlc(grant_dlc), .grant_rtr(grant_rtr)
    );

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] dir;
        logic [31:0] req;
        logic [5:0]  base;
        logic [4:0]  ma;
        logic [5:0]  pa;
        logic [4:0]  mb;
        logic [5:0]  pb;
        logic        ev;
        logic [4:0]  ei;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 6'd0, 5'd3,  6'd10, 5'd20, 6'd9,  1'b1, 5'd3 },
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF, 6'd7, 5'd0,  6'd7,  5'd0,  6'd7,  1'b1, 5'd31},
        '{32'h0000_00F0, 32'h0000_0000, 32'hFFFF_FFFF, 6'd1, 5'd5,  6'd2,  5'd30, 6'd63, 1'b1, 5'd5 },
        '{32'hFFFF_FFFF, 32'h0000_0FFF, 32'hFFFF_FFFF, 6'd4, 5'd11, 6'd60, 5'd12, 6'd50, 1'b1, 5'd12},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0001, 6'd0, 5'd31, 6'd63, 5'd1,  6'd63, 1'b1, 5'd0 },
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd5, 5'd2,  6'd9,  5'd3,  6'd9,  1'b0, 5'd0 },
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0300, 6'd2, 5'd8,  6'd40, 5'd9,  6'd40, 1'b1, 5'd9 },
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 6'd0, 5'd0,  6'd63, 5'd31, 6'd62, 1'b1, 5'd0 },
        '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 6'd3, 5'd1,  6'd9,  5'd2,  6'd9,  1'b0, 5'd0 },
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'hAAAA_AAAA, 6'd3, 5'd2,  6'd0,  5'd5,  6'd0,  1'b1, 5'd31},
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0022, 6'd9, 5'd1,  6'd9,  5'd5,  6'd8,  1'b1, 5'd1 }
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        rd_addr = a;
        #(100ps);
        d = rd_data;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        step();
        rst = 1'b0;
    endtask

    function automatic logic [31:0] ctl_word(input logic [5:0] p, input int i);
        return {18'd0, p, 3'd0, 1'(i & 1), 4'(i)};
    endfunction

    logic [31:0] r;

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        // table walk: R2 R3 R4 R8 R10
        for (int v = 0; v < NV; v++) begin
            do_reset();
            for (int i = 0; i < 32; i++) begin
                logic [5:0] p;
                p = (5'(i) == VEC[v].ma) ? VEC[v].pa :
                    (5'(i) == VEC[v].mb) ? VEC[v].pb : VEC[v].base;
                wr(6'(32 + i), ctl_word(p, i));
            end
            wr(6'd0, VEC[v].en);
            wr(6'd1, VEC[v].dir);
            wr(6'd2, VEC[v].req);
            step();
            check($sformatf("R2 R3 R4 R8 valid vec %0d", v), 32'(grant_valid), 32'(VEC[v].ev));
            if (VEC[v].ev) begin
                check($sformatf("R3 R4 idx vec %0d", v), 32'(grant_idx), 32'(VEC[v].ei));
                check($sformatf("R10 dlc vec %0d", v), 32'(grant_dlc), 32'(VEC[v].ei[3:0]));
                check($sformatf("R10 rtr vec %0d", v), 32'(grant_rtr), 32'(VEC[v].ei[0]));
            end
        end

        // R1 reset state
        do_reset();
        check("R1 grant_valid", 32'(grant_valid), 32'd0);
        for (int a = 0; a < 4; a++) begin
            rd(6'(a), r);
            check($sformatf("R1 reg %0d", a), r, 32'd0);
        end
        rd(6'd32, r);
        check("R1 ctl 0", r, 32'd0);

        // R5 request set semantics
        wr(6'd2, 32'h0000_0005);
        rd(6'd2, r);
        check("R5 set", r, 32'h0000_0005);
        wr(6'd2, 32'h0000_0000);
        rd(6'd2, r);
        check("R5 zero write", r, 32'h0000_0005);
        wr(6'd2, 32'h0000_0010);
        rd(6'd2, r);
        check("R5 accumulate", r, 32'h0000_0015);

        // R8 one-cycle lag, all priorities 0 -> slot 4 by tie rule
        wr(6'd0, 32'hFFFF_FFFF);
        check("R8 lag", 32'(grant_valid), 32'd0);
        step();
        check("R8 valid after edge", 32'(grant_valid), 32'd1);
        check("R4 idx tie", 32'(grant_idx), 32'd4);
        eng_ready = 1'b0;
        step();
        check("R8 not ready", 32'(grant_valid), 32'd0);
        eng_ready = 1'b1;
        step();
        check("R8 ready again", 32'(grant_valid), 32'd1);

        // R6 done pulse
        tx_done = 1'b1;
        done_idx = 5'd4;
        step();
        tx_done = 1'b0;
        rd(6'd2, r);
        check("R6 req cleared", r, 32'h0000_0005);
        rd(6'd3, r);
        check("R6 ack set", r, 32'h0000_0010);
        step();
        check("R6 next winner", 32'(grant_idx), 32'd2);

        // R7 completion clear
        wr(6'd3, 32'h0000_0000);
        rd(6'd3, r);
        check("R7 zero write", r, 32'h0000_0010);
        wr(6'd3, 32'h0000_0010);
        rd(6'd3, r);
        check("R7 clear", r, 32'h0000_0000);

        // R9 disable while pending
        wr(6'd0, ~32'h0000_0004);
        step();
        check("R9 idx after disable", 32'(grant_idx), 32'd0);
        wr(6'd0, ~32'h0000_0005);
        step();
        check("R9 none left", 32'(grant_valid), 32'd0);

        // R11 control word width
        wr(6'd41, 32'hFFFF_FFFF);
        rd(6'd41, r);
        check("R11 ctl readback", r, 32'h0000_3FFF);

        // R12 set and done collide on slot 3
        wr_en = 1'b1;
        wr_addr = 6'd2;
        wr_data = 32'h0000_0008;
        tx_done = 1'b1;
        done_idx = 5'd3;
        step();
        wr_en = 1'b0;
        tx_done = 1'b0;
        rd(6'd2, r);
        check("R12 req kept", r, 32'h0000_000D);
        rd(6'd3, r);
        check("R12 ack set", r, 32'h0000_0008);

        // R10 winner fields: slot 9 prio 63 beats slot 3 prio 0
        wr(6'd2, 32'h0000_0200);
        step();
        check("R10 idx", 32'(grant_idx), 32'd9);
        check("R10 dlc", 32'(grant_dlc), 32'hF);
        check("R10 rtr", 32'(grant_rtr), 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule